// File: doc/BRIEF.md
# Compartment Identifier CSR Tracker

This block keeps the identity of the security compartment that a core is running. It holds three identifier registers. The current-ID register is 0 while the supervisor runs and nonzero for any user compartment. The previous-ID register records the compartment that ran before the last switch. The supervisor-only shadow register preserves the previous-ID value across a trap. It also holds the address-translation control word and flags when that word selects compartment-based translation. The current ID goes straight to the translation unit.

Identifier changes come from four event strobes: an explicit switch carrying a target ID, an environment call, trap entry, and a supervisor return. An event arbiter reduces the strobes each cycle to one event kind: `EV_IDLE`, `EV_TRAP`, `EV_CALL`, `EV_RETURN` or `EV_SWITCH`. The register stage makes a transition for each kind. With `EV_IDLE` it holds, apart from permitted CSR writes. `EV_TRAP` is trap entry. `EV_CALL` is the environment call. `EV_RETURN` is the supervisor return. `EV_SWITCH` is the explicit switch.

A CSR port decodes each access to a register select: `SEL_CUR`, `SEL_PREV`, `SEL_SHADOW` or `SEL_XLATE`. It checks the access against the privilege level and returns read data and an illegal-access flag in the same cycle.

Top module: `cid_tracker`

## Requirements
- R1: After reset the current, previous and shadow IDs and the translation control word are all 0, so `cur_id` is 0 and `xlate_mode_on` is 0.
- R2: A lone switch (`sw_valid`) sets `cur_id` to `sw_target` and the previous ID to the old current ID on the next edge. This holds even when the target equals the current ID.
- R3: An environment call (`ecall`) sets the current ID to 0 and the previous ID to the old current ID on the next edge.
- R4: Trap entry (`trap`) sets the current ID to 0, the previous ID to the old current ID, and the shadow register to the old previous ID on the next edge.
- R5: A supervisor return (`sret`) restores the current ID from the previous ID and the previous ID from the shadow register. The shadow register is left unchanged.
- R6: When several strobes are high in one cycle, exactly one event acts. The order of priority is trap, then ecall, then sret, then switch.
- R7: The current ID (CSR address 0x5C0) is read-only in every privilege level. A write to it sets `csr_illegal` in the same cycle and leaves `cur_id` unchanged. Only the R2 to R5 events change it.
- R8: Any write in user mode (`priv_user`=1) is illegal and changes nothing. A supervisor may write the previous ID (0x5C1), the shadow ID (0x5C2) and the translation control word (0x180). The new value is readable from the next cycle. A write to an ID register in a cycle where any event acts is dropped without a flag.
- R9: In user mode, reads of 0x5C0 and 0x5C1 return the ID zero-extended in `csr_rdata`. Reads of 0x5C2 or 0x180 are illegal. An access to any other address is illegal in either mode. An illegal access returns 0 in `csr_rdata`.
- R10: `xlate_mode_on` is 1 exactly when bits [63:60] of the translation control word equal 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_valid | input | 1 | Explicit compartment switch strobe |
| sw_target | input | IDW | Target ID of the switch |
| ecall | input | 1 | Environment call strobe |
| trap | input | 1 | Trap entry strobe |
| sret | input | 1 | Supervisor return strobe |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor |
| csr_rd | input | 1 | CSR read request |
| csr_wr | input | 1 | CSR write request |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data, combinational |
| csr_illegal | output | 1 | Illegal CSR access, combinational |
| cur_id | output | IDW | Current compartment ID |
| xlate_mode_on | output | 1 | Compartment-based translation selected |

## Verification
A corrupt current ID shows on `cur_id` in the cycle after the faulty edge. A wrong previous or shadow ID is hidden until a supervisor read or an `sret` brings it out. For that reason, every event sequence is followed by supervisor reads of both registers, and return paths are used that depend on the shadow value. A wrong arbitration decision or access check shows in the same cycle on `csr_illegal` or `csr_rdata`, or one cycle later on `cur_id`.

// File: rtl/cid_pkg.sv
package cid_pkg;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_TRAP,
        EV_CALL,
        EV_RETURN,
        EV_SWITCH
    } ev_kind_e;

    typedef enum logic [1:0] {
        SEL_CUR,
        SEL_PREV,
        SEL_SHADOW,
        SEL_XLATE
    } csr_sel_e;

endpackage

// File: rtl/cid_event_arb.sv
module cid_event_arb
    import cid_pkg::*;
(
    input  logic     trap,
    input  logic     ecall,
    input  logic     sret,
    input  logic     sw_valid,
    output ev_kind_e kind
);

    // Fixed priority: trap, call, return, switch
    always_comb begin
        if (trap)          kind = EV_TRAP;
        else if (ecall)    kind = EV_CALL;
        else if (sret)     kind = EV_RETURN;
        else if (sw_valid) kind = EV_SWITCH;
        else               kind = EV_IDLE;
    end

endmodule

// File: rtl/cid_csr_port.sv
module cid_csr_port
    import cid_pkg::*;
#(
    parameter int          IDW         = 16,
    parameter int          XLEN        = 64,
    parameter logic [11:0] ADDR_CUR    = 12'h5C0,
    parameter logic [11:0] ADDR_PREV   = 12'h5C1,
    parameter logic [11:0] ADDR_SHADOW = 12'h5C2,
    parameter logic [11:0] ADDR_XLATE  = 12'h180
) (
    input  logic            priv_user,
    input  logic            csr_rd,
    input  logic            csr_wr,
    input  logic [11:0]     csr_addr,
    input  logic [IDW-1:0]  cur,
    input  logic [IDW-1:0]  prev,
    input  logic [IDW-1:0]  shadow,
    input  logic [XLEN-1:0] xlate,
    output logic            illegal,
    output logic [XLEN-1:0] rdata,
    output logic            we_prev,
    output logic            we_shadow,
    output logic            we_xlate
);

    localparam int PAD = XLEN - IDW;

    logic [IDW-1:0]  id_in  [3];
    logic [XLEN-1:0] id_ext [3];
    csr_sel_e        sel;
    logic            hit;
    logic            ok;

    assign id_in[0] = cur;
    assign id_in[1] = prev;
    assign id_in[2] = shadow;

    for (genvar g = 0; g < 3; g++) begin : g_ext
        if (PAD > 0) begin : g_pad
            assign id_ext[g] = {{PAD{1'b0}}, id_in[g]};
        end else begin : g_flat
            assign id_ext[g] = id_in[g];
        end
    end

    always_comb begin
        hit = 1'b1;
        sel = SEL_CUR;
        if (csr_addr == ADDR_CUR)         sel = SEL_CUR;
        else if (csr_addr == ADDR_PREV)   sel = SEL_PREV;
        else if (csr_addr == ADDR_SHADOW) sel = SEL_SHADOW;
        else if (csr_addr == ADDR_XLATE)  sel = SEL_XLATE;
        else                              hit = 1'b0;
    end

    always_comb begin
        illegal = 1'b0;
        if (csr_rd || csr_wr) begin
            if (!hit) begin
                illegal = 1'b1;
            end else begin
                unique case (sel)
                    SEL_CUR:    illegal = csr_wr;
                    SEL_PREV:   illegal = csr_wr && priv_user;
                    SEL_SHADOW: illegal = priv_user;
                    SEL_XLATE:  illegal = priv_user;
                endcase
            end
        end
    end

    assign ok = hit && !illegal;

    always_comb begin
        rdata = '0;
        if (csr_rd && ok) begin
            unique case (sel)
                SEL_CUR:    rdata = id_ext[0];
                SEL_PREV:   rdata = id_ext[1];
                SEL_SHADOW: rdata = id_ext[2];
                SEL_XLATE:  rdata = xlate;
            endcase
        end
    end

    assign we_prev   = csr_wr && ok && (sel == SEL_PREV);
    assign we_shadow = csr_wr && ok && (sel == SEL_SHADOW);
    assign we_xlate  = csr_wr && ok && (sel == SEL_XLATE);

endmodule

// File: rtl/cid_regs.sv
module cid_regs
    import cid_pkg::*;
#(
    parameter int IDW  = 16,
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ev_kind_e        kind,
    input  logic [IDW-1:0]  sw_target,
    input  logic            we_prev,
    input  logic            we_shadow,
    input  logic            we_xlate,
    input  logic [XLEN-1:0] wdata,
    output logic [IDW-1:0]  cur_q,
    output logic [IDW-1:0]  prev_q,
    output logic [IDW-1:0]  shadow_q,
    output logic [XLEN-1:0] xlate_q
);

    logic [IDW-1:0]  cur_n, prev_n, shadow_n;
    logic [XLEN-1:0] xlate_n;

    always_comb begin
        cur_n    = cur_q;
        prev_n   = prev_q;
        shadow_n = shadow_q;
        xlate_n  = we_xlate ? wdata : xlate_q;
        unique case (kind)
            EV_TRAP: begin
                cur_n    = '0;
                prev_n   = cur_q;
                shadow_n = prev_q;
            end
            EV_CALL: begin
                cur_n  = '0;
                prev_n = cur_q;
            end
            EV_RETURN: begin
                cur_n  = prev_q;
                prev_n = shadow_q;
            end
            EV_SWITCH: begin
                cur_n  = sw_target;
                prev_n = cur_q;
            end
            EV_IDLE: begin
                if (we_prev)   prev_n   = wdata[IDW-1:0];
                if (we_shadow) shadow_n = wdata[IDW-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            prev_q   <= '0;
            shadow_q <= '0;
            xlate_q  <= '0;
        end else begin
            cur_q    <= cur_n;
            prev_q   <= prev_n;
            shadow_q <= shadow_n;
            xlate_q  <= xlate_n;
        end
    end

endmodule

// File: rtl/cid_tracker.sv
module cid_tracker
    import cid_pkg::*;
#(
    parameter int          IDW         = 16,
    parameter int          XLEN        = 64,
    parameter logic [11:0] ADDR_CUR    = 12'h5C0,
    parameter logic [11:0] ADDR_PREV   = 12'h5C1,
    parameter logic [11:0] ADDR_SHADOW = 12'h5C2,
    parameter logic [11:0] ADDR_XLATE  = 12'h180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_valid,
    input  logic [IDW-1:0]  sw_target,
    input  logic            ecall,
    input  logic            trap,
    input  logic            sret,
    input  logic            priv_user,
    input  logic            csr_rd,
    input  logic            csr_wr,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    output logic [IDW-1:0]  cur_id,
    output logic            xlate_mode_on
);

    localparam int MODE_HI = XLEN - 1;

    ev_kind_e        kind;
    logic [IDW-1:0]  prev_q, shadow_q;
    logic [XLEN-1:0] xlate_q;
    logic            we_prev, we_shadow, we_xlate;

    cid_event_arb u_arb (
        .trap     (trap),
        .ecall    (ecall),
        .sret     (sret),
        .sw_valid (sw_valid),
        .kind     (kind)
    );

    cid_csr_port #(
        .IDW(IDW), .XLEN(XLEN),
        .ADDR_CUR(ADDR_CUR), .ADDR_PREV(ADDR_PREV),
        .ADDR_SHADOW(ADDR_SHADOW), .ADDR_XLATE(ADDR_XLATE)
    ) u_port (
        .priv_user (priv_user),
        .csr_rd    (csr_rd),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .cur       (cur_id),
        .prev      (prev_q),
        .shadow    (shadow_q),
        .xlate     (xlate_q),
        .illegal   (csr_illegal),
        .rdata     (csr_rdata),
        .we_prev   (we_prev),
        .we_shadow (we_shadow),
        .we_xlate  (we_xlate)
    );

    cid_regs #(.IDW(IDW), .XLEN(XLEN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .sw_target (sw_target),
        .we_prev   (we_prev),
        .we_shadow (we_shadow),
        .we_xlate  (we_xlate),
        .wdata     (csr_wdata),
        .cur_q     (cur_id),
        .prev_q    (prev_q),
        .shadow_q  (shadow_q),
        .xlate_q   (xlate_q)
    );

    assign xlate_mode_on = (xlate_q[MODE_HI -: 4] == 4'hF);

endmodule

// File: rtl/cid_tracker_checker.sv
module cid_tracker_checker #(
    parameter int          IDW         = 16,
    parameter logic [11:0] ADDR_SHADOW = 12'h5C2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sw_valid,
    input logic [IDW-1:0] sw_target,
    input logic           ecall,
    input logic           trap,
    input logic           sret,
    input logic           priv_user,
    input logic           csr_rd,
    input logic           csr_wr,
    input logic [11:0]    csr_addr,
    input logic           csr_illegal,
    input logic [IDW-1:0] cur_id,
    input logic [IDW-1:0] prev_q,
    input logic [IDW-1:0] shadow_q
);

    p_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && !trap && !ecall && !sret) |=>
            (cur_id == $past(sw_target)) && (prev_q == $past(cur_id)));

    p_call_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ecall && !trap) |=> (cur_id == '0) && (prev_q == $past(cur_id)));

    p_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (cur_id == '0) && (prev_q == $past(cur_id))
                 && (shadow_q == $past(prev_q)));

    p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sret && !trap && !ecall) |=>
            (cur_id == $past(prev_q)) && (prev_q == $past(shadow_q))
            && $stable(shadow_q));

    p_cur_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap && !ecall && !sret && !sw_valid) |=> $stable(cur_id));

    p_user_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_user && csr_wr) |-> csr_illegal);

    p_shadow_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_user && csr_rd && csr_addr == ADDR_SHADOW) |-> csr_illegal);

endmodule

bind cid_tracker cid_tracker_checker #(
    .IDW(IDW), .ADDR_SHADOW(ADDR_SHADOW)
) u_chk (.*);

// File: tb/cid_tracker_bench.sv
module cid_tracker_bench;

    localparam logic [11:0] A_CUR = 12'h5C0;
    localparam logic [11:0] A_PRV = 12'h5C1;
    localparam logic [11:0] A_SHD = 12'h5C2;
    localparam logic [11:0] A_XLT = 12'h180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_valid = 1'b0;
    logic [15:0] sw_target = '0;
    logic        ecall = 1'b0, trap = 1'b0, sret = 1'b0;
    logic        priv_user = 1'b0, csr_rd = 1'b0, csr_wr = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        csr_illegal;
    logic [15:0] cur_id;
    logic        xlate_mode_on;

    always #2 clk = ~clk;

    cid_tracker u_cid_tracker (.*);

    typedef struct {
        string       tag;
        logic        chk_acc;
        logic        exp_ill;
        logic        chk_rd;
        logic [63:0] exp_rd;
        logic [15:0] exp_cur;
        logic        exp_mode;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;

    logic [15:0] m_cur = '0, m_prev = '0, m_shd = '0;
    logic [63:0] m_xlt = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic t, input logic e, input logic s,
                       input logic sw, input logic [15:0] tgt, input logic u,
                       input logic rd, input logic wr, input logic [11:0] a,
                       input logic [63:0] wd);
        item_t it;
        logic hit, ill, anyev;
        logic [63:0] rv;
        logic [15:0] nc, np, ns;
        @(negedge clk);
        trap = t; ecall = e; sret = s; sw_valid = sw; sw_target = tgt;
        priv_user = u; csr_rd = rd; csr_wr = wr; csr_addr = a; csr_wdata = wd;
        hit = (a == A_CUR) || (a == A_PRV) || (a == A_SHD) || (a == A_XLT);
        ill = (rd || wr) && (!hit || (wr && a == A_CUR) || (u && wr)
              || (u && (a == A_SHD || a == A_XLT)));
        rv = '0;
        if (rd && !ill) begin
            if (a == A_CUR) rv = {48'h0, m_cur};
            else if (a == A_PRV) rv = {48'h0, m_prev};
            else if (a == A_SHD) rv = {48'h0, m_shd};
            else rv = m_xlt;
        end
        anyev = t || e || s || sw;
        nc = m_cur; np = m_prev; ns = m_shd;
        if (t) begin nc = '0; np = m_cur; ns = m_prev; end
        else if (e) begin nc = '0; np = m_cur; end
        else if (s) begin nc = m_prev; np = m_shd; end
        else if (sw) begin nc = tgt; np = m_cur; end
        else if (wr && !ill) begin
            if (a == A_PRV) np = wd[15:0];
            if (a == A_SHD) ns = wd[15:0];
        end
        if (wr && !ill && a == A_XLT) m_xlt = wd;
        m_cur = nc; m_prev = np; m_shd = ns;
        it.tag = tag; it.chk_acc = rd || wr; it.exp_ill = ill;
        it.chk_rd = rd; it.exp_rd = rv; it.exp_cur = m_cur;
        it.exp_mode = (m_xlt[63:60] == 4'hF);
        q.push_back(it);
    endtask

    task automatic ev(input string tag, input logic t, input logic e, input logic s,
                      input logic sw, input logic [15:0] tgt);
        cyc(tag, t, e, s, sw, tgt, 1'b0, 1'b0, 1'b0, 12'h0, 64'h0);
    endtask

    task automatic acc(input string tag, input logic u, input logic rd, input logic wr,
                       input logic [11:0] a, input logic [63:0] wd);
        cyc(tag, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, u, rd, wr, a, wd);
    endtask

    task automatic read_ids(input string tag);
        acc({tag, " prev"}, 1'b0, 1'b1, 1'b0, A_PRV, 64'h0);
        acc({tag, " shadow"}, 1'b0, 1'b1, 1'b0, A_SHD, 64'h0);
    endtask

    // Monitor: pops one expected item per driven cycle
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                if (it.chk_acc) chk({it.tag, " illegal"}, {63'h0, csr_illegal}, {63'h0, it.exp_ill});
                if (it.chk_rd)  chk({it.tag, " rdata"}, csr_rdata, it.exp_rd);
                @(posedge clk);
                #1;
                chk({it.tag, " cur_id"}, {48'h0, cur_id}, {48'h0, it.exp_cur});
                chk({it.tag, " mode"}, {63'h0, xlate_mode_on}, {63'h0, it.exp_mode});
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        acc("R1 cur read", 1'b1, 1'b1, 1'b0, A_CUR, 64'h0);
        read_ids("R1");
        acc("R1 xlate read", 1'b0, 1'b1, 1'b0, A_XLT, 64'h0);
        // R2 switches, including same target
        ev("R2 switch 5", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0005);
        ev("R2 switch same 5", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0005);
        read_ids("R2 same");
        ev("R2 switch 9", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0009);
        acc("R9 user read prev", 1'b1, 1'b1, 1'b0, A_PRV, 64'h0);
        // R4 trap, R5 return
        ev("R4 trap", 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        read_ids("R4");
        ev("R5 sret", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        read_ids("R5");
        // R3 ecall and return
        ev("R3 ecall", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        read_ids("R3");
        ev("R5 sret after call", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        read_ids("R5 call");
        // R6 priority
        ev("R6 trap over switch", 1'b1, 1'b0, 1'b0, 1'b1, 16'h0042);
        read_ids("R6 a");
        ev("R6 ecall over sret", 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        read_ids("R6 b");
        ev("R6 sret over switch", 1'b0, 1'b0, 1'b1, 1'b1, 16'h0077);
        read_ids("R6 c");
        ev("R6 all strobes", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0031);
        read_ids("R6 d");
        ev("R2 switch 12", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0012);
        // R7 current ID read-only
        acc("R7 user write cur", 1'b1, 1'b0, 1'b1, A_CUR, 64'h00AB);
        acc("R7 sup write cur", 1'b0, 1'b0, 1'b1, A_CUR, 64'h00CD);
        acc("R7 cur readback", 1'b0, 1'b1, 1'b0, A_CUR, 64'h0);
        // R8 writes
        acc("R8 user write prev", 1'b1, 1'b0, 1'b1, A_PRV, 64'h0055);
        acc("R8 user write shadow", 1'b1, 1'b0, 1'b1, A_SHD, 64'h0066);
        read_ids("R8 user");
        acc("R8 sup write prev", 1'b0, 1'b0, 1'b1, A_PRV, 64'h0123);
        acc("R8 sup write shadow", 1'b0, 1'b0, 1'b1, A_SHD, 64'h0456);
        read_ids("R8 sup");
        cyc("R8 write dropped by switch", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0021,
            1'b0, 1'b0, 1'b1, A_PRV, 64'h0999);
        read_ids("R8 drop");
        ev("R5 sret uses written shadow", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        read_ids("R5 shadow");
        // R9 illegal reads
        acc("R9 user read shadow", 1'b1, 1'b1, 1'b0, A_SHD, 64'h0);
        acc("R9 user read xlate", 1'b1, 1'b1, 1'b0, A_XLT, 64'h0);
        acc("R9 unmapped read", 1'b0, 1'b1, 1'b0, 12'h5C7, 64'h0);
        acc("R9 user read cur", 1'b1, 1'b1, 1'b0, A_CUR, 64'h0);
        // R10 translation mode
        acc("R10 mode F", 1'b0, 1'b0, 1'b1, A_XLT, 64'hF000_0000_0000_1234);
        acc("R10 user write xlate", 1'b1, 1'b0, 1'b1, A_XLT, 64'h0);
        acc("R10 xlate readback", 1'b0, 1'b1, 1'b0, A_XLT, 64'h0);
        acc("R10 mode E", 1'b0, 1'b0, 1'b1, A_XLT, 64'hE000_0000_0000_0000);
        acc("R10 mode F low bits clear", 1'b0, 1'b0, 1'b1, A_XLT, 64'hF000_0000_0000_0000);
        acc("R10 mode 7", 1'b0, 1'b0, 1'b1, A_XLT, 64'h7FFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        trap = 1'b0; ecall = 1'b0; sret = 1'b0; sw_valid = 1'b0;
        csr_rd = 1'b0; csr_wr = 1'b0;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule